// File: doc/BRIEF.md
# Prescaled Watchdog Timer with Reset Flag

This block is a watchdog for a system that runs unattended. A free-running up-counter advances once per prescaler tick. The tick rate is the system clock divided by a power of two that software selects. If software does not restart the counter before it runs past its all-ones value, the block emits a one-cycle reset request. In the same edge it drops its own enable, so the watchdog must be armed again after every reset.

Software reaches the block through a single-port register interface with two addresses. Address 0 is the control register: bit 7 is the enable, bit 5 is the restart strobe, and bits 2:0 are the divider code. Address 1 is the status register: bit 0 is a sticky flag that records that the last reset came from the watchdog rather than from the external reset input. The external reset input `rst` must be the hardware reset only. The block applies its own reset request to itself internally, so the flag survives it. Read data is registered: it shows the addressed register as it was in the cycle before the clock edge.

Top module: `pwdog_top`

## Requirements
- R1: After the external reset, `wdt_reset` is 0, the control register reads 0x00 and the status register reads 0x00.
- R2: While the enable (control bit 7) is 0, neither the counter nor the prescaler advances and `wdt_reset` stays 0, whatever divider code is held.
- R3: The divider code c (control bits 2:0) selects a tick every 8·2^c clock cycles, so code 000 divides by 8 and code 111 divides by 1024. If enable is written to 1 at clock edge E0 from a cleared state, `wdt_reset` is high in the cycle that follows edge E0 + 8·2^c·2^CNT_W, and not before.
- R4: `wdt_reset` is high for exactly one clock cycle per overflow.
- R5: The watchdog's own reset clears the control register to 0x00, with the enable at 0 and the code at 000. No further pulse follows until software enables the block again.
- R6: A watchdog overflow sets the status flag (status bit 0 reads 1). The flag stays set through the watchdog reset. Writing status with bit 0 at 0 clears it, and writing bit 0 at 1 leaves it unchanged.
- R7: The external reset clears the status flag and the control register.
- R8: Writing control with bit 5 at 1 zeroes both the counter and the prescaler at that edge, so the full timeout of R3 restarts from that edge. Bit 5 always reads 0.
- R9: Control bits 6, 5, 4 and 3 read as 0. Writing 1 to bits 6, 4 or 3 has no effect.
- R10: Writing the enable to 0 freezes the counter and the prescaler. Writing it back to 1 resumes the count from the frozen value, so the remaining time is the full timeout minus the cycles already counted.
- R11: Register addresses: 0 is control and 1 is status. `reg_rdata` shows the addressed register one clock edge after `reg_addr` is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | External hardware reset, synchronous, active high |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register address: 0 control, 1 status |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data of the addressed register |
| wdt_reset | output | 1 | One-cycle watchdog reset request |

## Verification
A wrong prescaler phase or a counter that miscounts does not show up in the read data. It shows up only as a reset pulse that comes early or late, and a difference of a single cycle is enough to reveal it. The bench therefore watches `wdt_reset` in every cycle of each timeout, for every divider code. A flag or enable that is not cleared shows up in the first register read after the pulse. A counter that does not hold while disabled, or that ignores the restart strobe, moves the next pulse by dozens of cycles.

// File: rtl/pwdog_pkg.sv
package pwdog_pkg;
  localparam int REG_W    = 8;
  localparam int EN_BIT   = 7;
  localparam int CLR_BIT  = 5;
  localparam int FLAG_BIT = 0;
  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_STAT = 1'b1;
endpackage

// File: rtl/pwdog_prescaler.sv
module pwdog_prescaler #(
  parameter int SEL_W    = 3,
  parameter int MIN_LOG2 = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic             clr_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int NCODE = 1 << SEL_W;
  localparam int PRE_W = MIN_LOG2 + NCODE - 1;

  logic [PRE_W-1:0] pre_q;
  logic [NCODE-1:0] tap;

  // one terminal-count detector per divider code
  for (genvar g = 0; g < NCODE; g++) begin : g_tap
    assign tap[g] = &pre_q[MIN_LOG2+g-1:0];
  end

  assign tick_o = en_i & tap[sel_i];

  always_ff @(posedge clk) begin
    if (rst || clr_i) pre_q <= '0;
    else if (en_i)    pre_q <= pre_q + 1'b1;
  end

  // R8: a restart leaves the prescaler at phase zero
  a_r8_pre_restart: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (pre_q == '0));
  // R10: the prescaler holds while disabled
  a_r10_pre_hold: assert property (@(posedge clk) disable iff (rst)
    (!en_i && !clr_i) |=> $stable(pre_q));
endmodule

// File: rtl/pwdog_counter.sv
module pwdog_counter #(
  parameter int CNT_W = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  input  logic tick_i,
  input  logic clr_i,
  output logic fire_o,
  output logic pulse_o
);
  logic [CNT_W-1:0] cnt_q;

  assign fire_o = tick_i & en_i & (&cnt_q) & ~clr_i;

  always_ff @(posedge clk) begin
    if (rst || clr_i)           cnt_q <= '0;
    else if (tick_i && en_i)    cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) pulse_o <= 1'b0;
    else     pulse_o <= fire_o;
  end

  // R4: the reset request lasts one cycle
  a_r4_one_cycle: assert property (@(posedge clk) disable iff (rst)
    pulse_o |=> !pulse_o);
  // R3: the request comes with the wrap to zero
  a_r3_wrap_pulse: assert property (@(posedge clk) disable iff (rst)
    fire_o |=> (pulse_o && cnt_q == '0));
  // R2: no advance while disabled
  a_r2_cnt_hold: assert property (@(posedge clk) disable iff (rst)
    (!en_i && !clr_i) |=> $stable(cnt_q));
  // R8: restart zeroes the count
  a_r8_cnt_restart: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (cnt_q == '0));
endmodule

// File: rtl/pwdog_regs.sv
module pwdog_regs
  import pwdog_pkg::*;
#(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we_i,
  input  logic             addr_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             fire_i,
  output logic             en_o,
  output logic [SEL_W-1:0] sel_o,
  output logic             clr_o,
  output logic [REG_W-1:0] rdata_o
);
  logic             en_q;
  logic [SEL_W-1:0] sel_q;
  logic             flag_q;
  logic [REG_W-1:0] rd_next;
  logic             wr_ctrl;
  logic             wr_stat;

  assign wr_ctrl = we_i && (addr_i == ADDR_CTRL);
  assign wr_stat = we_i && (addr_i == ADDR_STAT);
  assign clr_o   = wr_ctrl && wdata_i[CLR_BIT];
  assign en_o    = en_q;
  assign sel_o   = sel_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      sel_q  <= '0;
      flag_q <= 1'b0;
    end else if (fire_i) begin
      en_q   <= 1'b0;
      sel_q  <= '0;
      flag_q <= 1'b1;
    end else begin
      if (wr_ctrl) begin
        en_q  <= wdata_i[EN_BIT];
        sel_q <= wdata_i[SEL_W-1:0];
      end
      if (wr_stat && !wdata_i[FLAG_BIT]) flag_q <= 1'b0;
    end
  end

  always_comb begin
    rd_next = '0;
    if (addr_i == ADDR_CTRL) begin
      rd_next[EN_BIT]     = en_q;
      rd_next[SEL_W-1:0]  = sel_q;
    end else begin
      rd_next[FLAG_BIT]   = flag_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_o <= '0;
    else     rdata_o <= rd_next;
  end

  // R5, R6: overflow disarms and flags
  a_r5_disarm: assert property (@(posedge clk) disable iff (rst)
    fire_i |=> (!en_q && sel_q == '0 && flag_q));
  // R6: software clear of the flag
  a_r6_flag_clear: assert property (@(posedge clk) disable iff (rst)
    (wr_stat && !wdata_i[FLAG_BIT] && !fire_i) |=> !flag_q);
  // R6: flag is sticky otherwise
  a_r6_flag_hold: assert property (@(posedge clk) disable iff (rst)
    (!fire_i && !wr_stat) |=> $stable(flag_q));
endmodule

// File: rtl/pwdog_top.sv
module pwdog_top
  import pwdog_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int SEL_W    = 3,
  parameter int MIN_LOG2 = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_we,
  input  logic             reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             wdt_reset
);
  logic             en;
  logic [SEL_W-1:0] sel;
  logic             clr;
  logic             tick;
  logic             fire;
  logic             pre_clr;

  assign pre_clr = clr | fire;

  pwdog_regs #(.SEL_W(SEL_W)) u_regs (
    .clk(clk), .rst(rst), .we_i(reg_we), .addr_i(reg_addr),
    .wdata_i(reg_wdata), .fire_i(fire), .en_o(en), .sel_o(sel),
    .clr_o(clr), .rdata_o(reg_rdata)
  );

  pwdog_prescaler #(.SEL_W(SEL_W), .MIN_LOG2(MIN_LOG2)) u_pre (
    .clk(clk), .rst(rst), .en_i(en), .clr_i(pre_clr), .sel_i(sel),
    .tick_o(tick)
  );

  pwdog_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .en_i(en), .tick_i(tick), .clr_i(clr),
    .fire_o(fire), .pulse_o(wdt_reset)
  );
endmodule

// File: tb/pwdog_top_test.sv
module pwdog_top_test;
  localparam int CNT_W = 4;
  localparam int SEL_W = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_we = 1'b0;
  logic       reg_addr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       wdt_reset;

  int vecs = 0;
  int errs = 0;
  logic [7:0] rv;

  always #4 clk = ~clk;

  pwdog_top #(.CNT_W(CNT_W), .SEL_W(SEL_W), .MIN_LOG2(3)) uut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .wdt_reset(wdt_reset)
  );

  function automatic int timeout(int code);
    return (8 << code) * (1 << CNT_W);
  endfunction

  task automatic check(string req, int act, int exp);
    vecs++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // called at a negedge; the write lands on the next posedge
  task automatic wr(logic a, logic [7:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = 8'h00;
  endtask

  task automatic rd(logic a, output logic [7:0] d);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  // entered in cycle 1 after the arming edge; pulse expected in cycle n+1
  task automatic expect_pulse(int n, string req);
    int early = 0;
    for (int c = 1; c <= n; c++) begin
      if (c > 1) @(negedge clk);
      if (wdt_reset) early++;
    end
    check({req, " no early pulse"}, early, 0);
    @(negedge clk);
    check({req, " pulse on time"}, int'(wdt_reset), 1);
    @(negedge clk);
    check("R4 pulse one cycle", int'(wdt_reset), 0);
  endtask

  task automatic quiet(int n, string req);
    int seen = 0;
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      if (wdt_reset) seen++;
    end
    check(req, seen, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 wdt_reset", int'(wdt_reset), 0);
    rd(1'b0, rv); check("R1 ctrl", int'(rv), 8'h00);
    rd(1'b1, rv); check("R1 status", int'(rv), 8'h00);

    // R2 disabled with code held
    wr(1'b0, 8'h07);
    rd(1'b0, rv); check("R11 ctrl readback", int'(rv), 8'h07);
    quiet(2 * timeout(7), "R2 no pulse while disabled");

    // R9 unused bits ignored, R8 clear bit reads 0
    wr(1'b0, 8'h7B);
    rd(1'b0, rv); check("R9 unused bits read 0", int'(rv), 8'h03);
    wr(1'b0, 8'h00);

    // R3 sweep of all divider codes, R5 and R6 after each
    for (int code = 0; code < 8; code++) begin
      wr(1'b0, 8'h80 | 8'(code));
      expect_pulse(timeout(code), "R3");
      rd(1'b0, rv); check("R5 ctrl cleared", int'(rv), 8'h00);
      rd(1'b1, rv); check("R6 flag set", int'(rv), 8'h01);
    end
    quiet(timeout(0) * 2, "R5 no pulse after disarm");

    // R6 writing 1 keeps, writing 0 clears
    wr(1'b1, 8'h01);
    rd(1'b1, rv); check("R6 write 1 keeps flag", int'(rv), 8'h01);
    wr(1'b1, 8'hFE);
    rd(1'b1, rv); check("R6 write 0 clears flag", int'(rv), 8'h00);

    // R8 restart mid-count
    wr(1'b0, 8'h80);
    repeat (99) @(negedge clk);
    wr(1'b0, 8'hA0);
    expect_pulse(timeout(0), "R8 restart");

    // R10 freeze and resume
    wr(1'b0, 8'h80);
    repeat (49) @(negedge clk);
    wr(1'b0, 8'h00);
    quiet(300, "R10 frozen no pulse");
    wr(1'b0, 8'h80);
    expect_pulse(timeout(0) - 50, "R10 resume");

    // R7 external reset clears the flag and control
    rd(1'b1, rv); check("R6 flag before ext reset", int'(rv), 8'h01);
    wr(1'b0, 8'h05);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    rd(1'b1, rv); check("R7 flag cleared", int'(rv), 8'h00);
    rd(1'b0, rv); check("R7 ctrl cleared", int'(rv), 8'h00);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule